// File: doc/BRIEF.md
# Packet Memory Pointer/Data Access Port

This block lets a host reach the bytes of a packet buffer through two small registers instead of a wide address bus. The host loads a pointer register with an offset inside a packet and a few mode bits. It then moves data through a single data register, using 16-bit or 8-bit accesses. Each data access becomes a read or a write of an internal packet RAM. The RAM address is the packet number times 256 plus the pointer offset, wrapped to the RAM size.

The packet number is never given with the access. A pointer bit picks where it comes from: either a host-writable packet-number register, or the head of the receive queue, which is supplied from outside. With auto-increment enabled, the offset steps forward after every accepted data access by the width of that access. A host can therefore stream a whole stored frame through one register: status word, length word, addresses, payload and the trailing control byte. In read mode the word under the pointer is fetched ahead of time, so the first read after loading the pointer already returns data.

Top module: `pktmem_port`

## Requirements
- R1: After a synchronous reset, `host_rvalid` and `host_rdata` are 0. The pointer holds offset 0 with all mode bits clear (write mode, no auto-increment, packet-number register as source). The packet-number register holds 0.
- R2: Writing register select 0 loads the pointer. Bits 10:0 are the offset, bit 15 selects the packet source (1 = `rxq_head`, 0 = packet-number register), bit 14 enables auto-increment, and bit 13 selects read mode. The byte address of a data access is (packet × 256 + offset) modulo 256·2^PNUM_W. The source is sampled live, so a change of `rxq_head` is followed.
- R3: Bytes are little-endian: an even byte address is bits 7:0 of the 16-bit word and an odd one is bits 15:8. A word access ignores address bit 0. A byte read returns the byte in `host_rdata[7:0]` with bits 15:8 zero.
- R4: In write mode, a word write to the data register (select 2, `host_byte` = 0) stores both bytes of `host_wdata`. A byte write stores `host_wdata[7:0]` at the addressed byte only and leaves the other byte of that word unchanged.
- R5: With auto-increment set, each accepted data access advances the offset by 2 (word) or 1 (byte), wrapping within 11 bits. With it clear, the offset does not change.
- R6: While read mode is set, data writes leave the RAM and the offset unchanged. While it is clear, data reads produce no `host_rvalid` and leave the offset unchanged.
- R7: In read mode, a data read issued at least two clock edges after the pointer write or the previous data read returns the data one cycle after the strobe. `host_rvalid` pulses for exactly that cycle and at no other time.
- R8: Writing register select 1 loads the packet-number register with `host_wdata[PNUM_W-1:0]`. The upper bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the selected register, one cycle |
| host_rd | input | 1 | Read strobe for the data register, one cycle |
| host_sel | input | 2 | Register select: 0 pointer, 1 packet number, 2 data |
| host_byte | input | 1 | 1 for a byte data access, 0 for a word access |
| host_wdata | input | 16 | Write data |
| rxq_head | input | PNUM_W | Packet number at the head of the receive queue |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |

## Verification
Every packet page of the RAM is filled by streaming word writes. It is then read back with streaming word reads through the packet-number register, which separates each page from every other page and each word from its neighbours. Byte reads starting at odd and even offsets, run through the receive-queue source while the packet-number register points elsewhere, check lane order and the step of 1. Byte writes with junk in the upper half, word reads at odd offsets, and accesses straddling offset 2047 cover lane masking, alignment and wrap. Accesses made in the wrong direction are followed by a read that shows neither the RAM nor the offset moved.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
  localparam int OFF_W = 11;
  localparam int DATA_W = 16;
  localparam int LANES = DATA_W / 8;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_PNUM = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic             from_rxq;
    logic             auto_inc;
    logic             rd_mode;
    logic [OFF_W-1:0] off;
  } ptr_t;
endpackage

// File: rtl/ppd_ptr_reg.sv
module ppd_ptr_reg
  import ppd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  ptr_t load_val,
  input  logic step,
  input  logic step_byte,
  output ptr_t ptr_q
);
  logic [OFF_W-1:0] stride;

  always_comb begin
    stride = step_byte ? OFF_W'(1) : OFF_W'(2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= load_val;
    end else if (step && ptr_q.auto_inc) begin
      ptr_q.off <= ptr_q.off + stride;
    end
  end
endmodule

// File: rtl/ppd_addr_gen.sv
module ppd_addr_gen
  import ppd_pkg::*;
#(
  parameter int PNUM_W     = 3,
  parameter int PAGE_SHIFT = 8,
  localparam int ADDR_W    = PNUM_W + PAGE_SHIFT
) (
  input  ptr_t              ptr,
  input  logic [PNUM_W-1:0] rxq_head,
  input  logic [PNUM_W-1:0] pnum,
  output logic [ADDR_W-2:0] word_addr,
  output logic              lane
);
  logic [PNUM_W-1:0] pkt;
  logic [ADDR_W-1:0] byte_addr;

  always_comb begin
    pkt       = ptr.from_rxq ? rxq_head : pnum;
    byte_addr = {pkt, {PAGE_SHIFT{1'b0}}} + ADDR_W'(ptr.off);
    word_addr = byte_addr[ADDR_W-1:1];
    lane      = byte_addr[0];
  end
endmodule

// File: rtl/ppd_bram.sv
module ppd_bram
  import ppd_pkg::*;
#(
  parameter int WORD_AW = 10,
  localparam int WORDS  = 1 << WORD_AW
) (
  input  logic               clk,
  input  logic               re,
  input  logic               we,
  input  logic [LANES-1:0]   be,
  input  logic [WORD_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [WORDS];

    always_ff @(posedge clk) begin
      if (we && be[g]) begin
        mem[addr] <= wdata[g*8 +: 8];
      end
      if (re) begin
        rdata[g*8 +: 8] <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/ppd_rd_port.sv
module ppd_rd_port
  import ppd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              byte_acc,
  input  logic              lane,
  input  logic [DATA_W-1:0] mem_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] shaped;

  always_comb begin
    if (byte_acc) begin
      shaped = {8'h00, (lane ? mem_q[15:8] : mem_q[7:0])};
    end else begin
      shaped = mem_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= fire;
      if (fire) begin
        rdata <= shaped;
      end
    end
  end
endmodule

// File: rtl/pktmem_port.sv
module pktmem_port
  import ppd_pkg::*;
#(
  parameter int PNUM_W     = 3,
  parameter int PAGE_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic              host_byte,
  input  logic [15:0]       host_wdata,
  input  logic [PNUM_W-1:0] rxq_head,
  output logic [15:0]       host_rdata,
  output logic              host_rvalid
);
  localparam int ADDR_W  = PNUM_W + PAGE_SHIFT;
  localparam int WORD_AW = ADDR_W - 1;

  ptr_t               ptr_q;
  ptr_t               ptr_load;
  logic [PNUM_W-1:0]  pnum_q;
  logic [WORD_AW-1:0] word_addr;
  logic               lane;
  logic [DATA_W-1:0]  mem_q;
  logic [DATA_W-1:0]  mem_wdata;
  logic [LANES-1:0]   mem_be;
  logic               sel_ptr, sel_pnum, sel_data;
  logic               wr_fire, rd_fire;

  logic [OFF_W-1:0]   cur_off;
  logic               cur_ainc;
  logic               cur_rdm;

  always_comb begin
    sel_ptr  = host_sel == SEL_PTR;
    sel_pnum = host_sel == SEL_PNUM;
    sel_data = host_sel == SEL_DATA;
    wr_fire  = host_wr && sel_data && !ptr_q.rd_mode;
    rd_fire  = host_rd && !host_wr && sel_data && ptr_q.rd_mode;
    ptr_load = ptr_t'({host_wdata[15:13], host_wdata[OFF_W-1:0]});
    if (host_byte) begin
      mem_wdata = {host_wdata[7:0], host_wdata[7:0]};
      mem_be    = lane ? 2'b10 : 2'b01;
    end else begin
      mem_wdata = host_wdata;
      mem_be    = 2'b11;
    end
    cur_off  = ptr_q.off;
    cur_ainc = ptr_q.auto_inc;
    cur_rdm  = ptr_q.rd_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pnum_q <= '0;
    end else if (host_wr && sel_pnum) begin
      pnum_q <= host_wdata[PNUM_W-1:0];
    end
  end

  ppd_ptr_reg u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (host_wr && sel_ptr),
    .load_val  (ptr_load),
    .step      (wr_fire || rd_fire),
    .step_byte (host_byte),
    .ptr_q     (ptr_q)
  );

  ppd_addr_gen #(
    .PNUM_W     (PNUM_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_addr (
    .ptr       (ptr_q),
    .rxq_head  (rxq_head),
    .pnum      (pnum_q),
    .word_addr (word_addr),
    .lane      (lane)
  );

  ppd_bram #(
    .WORD_AW (WORD_AW)
  ) u_ram (
    .clk   (clk),
    .re    (ptr_q.rd_mode),
    .we    (wr_fire),
    .be    (mem_be),
    .addr  (word_addr),
    .wdata (mem_wdata),
    .rdata (mem_q)
  );

  ppd_rd_port u_rd (
    .clk      (clk),
    .rst      (rst),
    .fire     (rd_fire),
    .byte_acc (host_byte),
    .lane     (lane),
    .mem_q    (mem_q),
    .rdata    (host_rdata),
    .rvalid   (host_rvalid)
  );
endmodule

// File: rtl/ppd_checker.sv
module ppd_checker
  import ppd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic             host_rd,
  input logic [1:0]       host_sel,
  input logic             host_byte,
  input logic             host_rvalid,
  input logic [OFF_W-1:0] cur_off,
  input logic             cur_ainc,
  input logic             cur_rdm
);
  logic data_sel, wr_ok, rd_ok, acc_ok;

  always_comb begin
    data_sel = host_sel == SEL_DATA;
    wr_ok    = host_wr && data_sel && !cur_rdm;
    rd_ok    = host_rd && !host_wr && data_sel && cur_rdm;
    acc_ok   = wr_ok || rd_ok;
  end

  AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(rd_ok)); // R7
  AST_READ_GIVES_RVALID: assert property (@(posedge clk) disable iff (rst)
    rd_ok |=> host_rvalid); // R7
  AST_IDLE_OFF_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!host_wr && !host_rd) |=> $stable(cur_off)); // R5
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && cur_ainc && !host_byte) |=> (cur_off - $past(cur_off)) == OFF_W'(2)); // R5
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && cur_ainc && host_byte) |=> (cur_off - $past(cur_off)) == OFF_W'(1)); // R5
  AST_NO_STEP_WITHOUT_AINC: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && !cur_ainc) |=> $stable(cur_off)); // R5
  AST_WRITE_IN_READ_MODE: assert property (@(posedge clk) disable iff (rst)
    (host_wr && data_sel && cur_rdm) |=> ($stable(cur_off) && cur_rdm)); // R6
  AST_READ_IN_WRITE_MODE: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr && data_sel && !cur_rdm) |=> (!host_rvalid && $stable(cur_off))); // R6
endmodule

bind pktmem_port ppd_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_sel    (host_sel),
  .host_byte   (host_byte),
  .host_rvalid (host_rvalid),
  .cur_off     (cur_off),
  .cur_ainc    (cur_ainc),
  .cur_rdm     (cur_rdm)
);

// File: tb/pktmem_port_tb_top.sv
module pktmem_port_tb_top;
  localparam int PNUM_W    = 3;
  localparam int MEM_BYTES = 256 << PNUM_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_wr = 1'b0;
  logic              host_rd = 1'b0;
  logic [1:0]        host_sel = 2'd0;
  logic              host_byte = 1'b0;
  logic [15:0]       host_wdata = 16'h0;
  logic [PNUM_W-1:0] rxq_head = '0;
  logic [15:0]       host_rdata;
  logic              host_rvalid;

  always #4 clk = ~clk;

  pktmem_port #(.PNUM_W(PNUM_W)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_sel    (host_sel),
    .host_byte   (host_byte),
    .host_wdata  (host_wdata),
    .rxq_head    (rxq_head),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  logic [7:0] model [MEM_BYTES];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  int b_off = 0;
  int b_pnum = 0;
  int b_rxh = 0;
  bit b_rcv = 0, b_ainc = 0, b_rdm = 0;

  function automatic int cur_addr();
    int pk;
    pk = b_rcv ? b_rxh : b_pnum;
    return ((pk << 8) + b_off) % MEM_BYTES;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] sel, logic [15:0] d, bit byt);
    host_sel = sel; host_wdata = d; host_byte = byt; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic set_ptr(bit rcv, bit ainc, bit rdm, int off);
    wr_reg(2'd0, {rcv, ainc, rdm, 2'b00, 11'(off)}, 1'b0);
    b_rcv = rcv; b_ainc = ainc; b_rdm = rdm; b_off = off % 2048;
  endtask

  task automatic set_pnum(int p);
    wr_reg(2'd1, 16'(p), 1'b0);
    b_pnum = p % (1 << PNUM_W);
  endtask

  task automatic data_wr(bit byt, logic [15:0] v);
    int a;
    a = cur_addr();
    wr_reg(2'd2, v, byt);
    if (!b_rdm) begin
      if (byt) model[a] = v[7:0];
      else begin
        model[a & ~1] = v[7:0];
        model[a | 1]  = v[15:8];
      end
      if (b_ainc) b_off = (b_off + (byt ? 1 : 2)) % 2048;
    end
  endtask

  task automatic data_rd(string req, bit byt);
    int a;
    logic [15:0] exp;
    @(negedge clk);
    a = cur_addr();
    host_sel = 2'd2; host_byte = byt; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    if (b_rdm) begin
      exp = byt ? {8'h00, model[a]} : {model[a | 1], model[a & ~1]};
      check(req, {15'h0, host_rvalid}, 16'h1);
      check(req, host_rdata, exp);
      if (b_ainc) b_off = (b_off + (byt ? 1 : 2)) % 2048;
    end else begin
      check(req, {15'h0, host_rvalid}, 16'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rvalid after reset", {15'h0, host_rvalid}, 16'h0);
    check("R1 rdata after reset", host_rdata, 16'h0);
    // R1: reset pointer is write mode, offset 0, no auto-increment, page 0
    data_wr(1'b0, 16'hA55A);
    data_wr(1'b0, 16'h1234);
    set_ptr(0, 0, 1, 0);
    data_rd("R1 R5 reset pointer", 1'b0);
    @(negedge clk);
    check("R7 single rvalid pulse", {15'h0, host_rvalid}, 16'h0);

    // Fill every page: R2 R4 R5 R8
    for (int p = 0; p < (1 << PNUM_W); p++) begin
      set_pnum(p);
      set_ptr(0, 1, 0, 0);
      for (int w = 0; w < 128; w++)
        data_wr(1'b0, 16'(p * 16'h1111) ^ 16'(w * 16'h0203) ^ 16'h5A00);
    end
    for (int p = 0; p < (1 << PNUM_W); p++) begin
      set_pnum(p);
      set_ptr(0, 1, 1, 0);
      for (int w = 0; w < 128; w++) data_rd("R2 R5 R7 word stream", 1'b0);
    end

    // Byte reads through receive head: R2 R3 R5
    for (int p = 0; p < (1 << PNUM_W); p++) begin
      rxq_head = PNUM_W'(p); b_rxh = p;
      set_ptr(1, 1, 1, 3 + p * 5);
      for (int i = 0; i < 9; i++) data_rd("R3 R5 byte stream", 1'b1);
    end
    set_ptr(1, 0, 1, 16);
    for (int p = 0; p < (1 << PNUM_W); p++) begin
      rxq_head = PNUM_W'((p * 3) % (1 << PNUM_W)); b_rxh = (p * 3) % (1 << PNUM_W);
      data_rd("R2 live head", 1'b0);
    end

    // Byte writes keep neighbour byte: R4
    set_pnum(2);
    set_ptr(0, 1, 0, 49);
    for (int i = 0; i < 6; i++) data_wr(1'b1, {8'hEE, 8'(8'h70 + i)});
    set_ptr(0, 1, 1, 48);
    for (int i = 0; i < 4; i++) data_rd("R4 byte write", 1'b0);

    // Word read at odd offset is aligned and does not step: R3 R5
    set_ptr(0, 0, 1, 19);
    data_rd("R3 aligned word", 1'b0);
    data_rd("R5 no step", 1'b0);

    // Offset wrap: R5
    set_pnum(5);
    set_ptr(0, 1, 0, 2046);
    data_wr(1'b0, 16'hBEEF);
    data_wr(1'b0, 16'hCAFE);
    set_ptr(0, 1, 0, 2047);
    data_wr(1'b1, 16'h0042);
    data_wr(1'b1, 16'h0017);
    set_ptr(0, 1, 1, 2046);
    data_rd("R5 wrap", 1'b0);
    data_rd("R5 wrap", 1'b0);

    // Wrong-direction accesses: R6
    set_pnum(1);
    set_ptr(0, 1, 1, 64);
    data_wr(1'b0, 16'hDEAD);
    data_rd("R6 write in read mode", 1'b0);
    set_ptr(0, 1, 0, 80);
    data_rd("R6 read in write mode", 1'b0);
    data_wr(1'b1, 16'h00AB);
    set_ptr(0, 0, 1, 80);
    data_rd("R6 offset held", 1'b1);
    data_rd("R6 offset held", 1'b0);

    // Packet-number register keeps low bits: R8
    wr_reg(2'd1, 16'hFFF9, 1'b0);
    b_pnum = 16'hFFF9 % (1 << PNUM_W);
    set_ptr(0, 0, 1, 6);
    data_rd("R8 pnum truncation", 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule